// File: doc/BRIEF.md
# DMA Register File and Interrupt Controller

This block holds the software-visible registers of a multi-channel DMA engine and turns the engines' completion and error reports into one level-sensitive interrupt. The CPU reaches it through a word-wide register port. Each channel has three words: a base address, a block-control word and a channel-control word. Bit 24 of the channel-control word is the busy/enable bit, which the transfer engine clears when it stops. Two global words sit above the channel windows. The first is an arbitration word in which channel n owns the nibble at bits 4n+3:4n. The top bit of that nibble is the channel's master enable and the lower three bits are its priority. The second is an interrupt word. It mixes plain settings, sticky per-channel flags that software clears by writing one to them, a bus-error bit and a computed master flag.

The transfer engines send a one-cycle completion pulse and a one-cycle bus-error pulse per channel. From these events the block clears busy bits, raises flags and drives `irq`. It also gives each engine a `may_run` qualifier, which is high only while software has both enabled and started that channel.

The register port is a request channel with no back-pressure. The block accepts a request in every cycle in which `req_valid` is high, so there is no ready signal. Every read is answered on `rsp_valid`/`rsp_rdata` exactly one cycle later, and the response cannot be stalled.

Top module: `dma_regirq_ctrl`

## Requirements
- R1: After reset, the arbitration word (offset 0x70) reads 0x07654321. The interrupt word (0x74) and every channel word read 0. `irq`, `rsp_valid` and every `may_run` bit are low.
- R2: For a channel index n = addr[7:4] below NUM_CH, the low nibble selects the word: 0x0 is the base address, 0x4 is block control and 0x8 is channel control. Each of these words stores all 32 written bits and reads them back.
- R3: Any other address reads 0, and a write to it changes no register. This includes low nibbles 0xC and above inside a channel window, index 7 apart from 0x70 and 0x74, and all addresses 0x78 and higher.
- R4: A write to the interrupt word takes the written value only in bits 5:0, bit 15 and bits 23:16. Bits 14:6 keep their value and read 0.
- R5: In a write to the interrupt word, a 1 in bit 24+n clears channel n's flag, and a 0 leaves it unchanged. A flag becomes set only through an event.
- R6: A completion pulse on channel n clears channel-control bit 24. It sets flag bit 24+n only when interrupt-word bit 16+n is 1.
- R7: A bus-error pulse on channel n clears channel-control bit 24 and sets interrupt-word bit 15. It also sets flag bit 24+n whatever the value of bit 16+n.
- R8: `may_run[n]` is high exactly when arbitration bit 4n+3 is 1 and channel-control bit 24 of channel n is 1.
- R9: Interrupt-word bit 31 is read-only. It equals bit 15 OR (bit 23 AND any n with both bit 16+n and bit 24+n set). `irq` equals bit 31 in every cycle.
- R10: If a flag-setting event and a write-one-to-clear of the same flag occur in the same cycle, the flag ends up set.
- R11: If a CPU write to a channel-control word and a completion or bus-error pulse on that channel occur in the same cycle, the written value is stored, busy bit included.
- R12: `rsp_valid` is high exactly in the cycle after a read request and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| done_evt | input | NUM_CH | Per-channel transfer-complete pulse |
| berr_evt | input | NUM_CH | Per-channel bus-error pulse |
| may_run | output | NUM_CH | Per-channel transfer qualifier |
| irq | output | 1 | Level interrupt, equal to the master flag |

## Verification
The bench builds the block with its default parameters: seven channels and an 8-bit offset. With these values the highest channel window (0x6x) can be tested, as can the unmapped channel-7 window next to the two global words, and every flag bit from 24 to 30. The bench runs the same-cycle collisions between events and software writes on a live channel. It also shows the master-enable gate hiding a flag that is set while the bus-error bit still forces the interrupt.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BUSY_BIT  = 24;
  localparam int unsigned BERR_BIT  = 15;
  localparam int unsigned IEN_LSB   = 16;
  localparam int unsigned IMEN_BIT  = 23;
  localparam int unsigned FLAG_LSB  = 24;
  localparam int unsigned MFLAG_BIT = 31;

  localparam logic [3:0] LO_BASE = 4'h0;
  localparam logic [3:0] LO_BLK  = 4'h4;
  localparam logic [3:0] LO_CTRL = 4'h8;

  localparam logic [7:0] OFS_ARB = 8'h70;
  localparam logic [7:0] OFS_INT = 8'h74;

  localparam logic [WORD_W-1:0] ARB_RESET = 32'h0765_4321;
  localparam logic [WORD_W-1:0] INT_WMASK = 32'h00FF_803F;

  typedef struct packed {
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] blk;
    logic [WORD_W-1:0] ctrl;
  } chan_regs_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_blk,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done_evt,
  input  logic              berr_evt,
  output chan_regs_t        regs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      if (wr_base) regs_q.base <= wdata;
      if (wr_blk)  regs_q.blk  <= wdata;
      if (wr_ctrl) begin
        regs_q.ctrl <= wdata;
      end else if (done_evt || berr_evt) begin
        regs_q.ctrl[BUSY_BIT] <= 1'b0;
      end
    end
  end

  // R6
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_evt || berr_evt) && !wr_ctrl) |=> !regs_q.ctrl[BUSY_BIT]);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (regs_q.ctrl == $past(wdata)));
endmodule

// File: rtl/dma_arb_reg.sv
module dma_arb_reg
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NUM_CH-1:0] busy,
  output logic [WORD_W-1:0] arb_q,
  output logic [NUM_CH-1:0] may_run
);
  always_ff @(posedge clk) begin
    if (!rst_n)     arb_q <= ARB_RESET;
    else if (wr_en) arb_q <= wdata;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_gate
    assign may_run[n] = arb_q[4*n+3] & busy[n];
  end
endmodule

// File: rtl/dma_irq_reg.sv
module dma_irq_reg
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [NUM_CH-1:0] berr_evt,
  output logic [WORD_W-1:0] int_q,
  output logic              irq
);
  localparam logic [WORD_W-1:0] CLR_MASK =
    ((WORD_W'(1) << NUM_CH) - WORD_W'(1)) << FLAG_LSB;

  logic [WORD_W-2:0] st_q, st_d;
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] flags;
  logic              master;

  assign flags   = st_q[FLAG_LSB +: NUM_CH];
  assign set_vec = (done_evt & st_q[IEN_LSB +: NUM_CH]) | berr_evt;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d = (st_q & ~INT_WMASK[WORD_W-2:0]) | (wdata[WORD_W-2:0] & INT_WMASK[WORD_W-2:0]);
      st_d = st_d & ~(wdata[WORD_W-2:0] & CLR_MASK[WORD_W-2:0]);
    end
    st_d[FLAG_LSB +: NUM_CH] = st_d[FLAG_LSB +: NUM_CH] | set_vec;
    if (|berr_evt) st_d[BERR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign master = st_q[BERR_BIT] |
                  (st_q[IMEN_BIT] & (|(st_q[IEN_LSB +: NUM_CH] & flags)));
  assign int_q  = {master, st_q};
  assign irq    = master;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R7
  berr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|berr_evt) |=> st_q[BERR_BIT]);

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/dma_regirq_ctrl.sv
module dma_regirq_ctrl
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [NUM_CH-1:0] berr_evt,
  output logic [NUM_CH-1:0] may_run,
  output logic              irq
);
  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  idx;
  logic [3:0]        lo;
  logic              wr, rd, chan_hit, arb_hit, int_hit;
  chan_regs_t        ch_q [NUM_CH];
  logic [NUM_CH-1:0] busy;
  logic [WORD_W-1:0] arb_q, int_q, rd_mux;

  assign idx      = req_addr[ADDR_W-1:4];
  assign lo       = req_addr[3:0];
  assign wr       = req_valid & req_write;
  assign rd       = req_valid & ~req_write;
  assign chan_hit = (int'(idx) < int'(NUM_CH));
  assign arb_hit  = (req_addr == ADDR_W'(OFS_ARB));
  assign int_hit  = (req_addr == ADDR_W'(OFS_INT));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic sel;
    assign sel = wr & chan_hit & (int'(idx) == n);
    dma_chan_regs u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (sel & (lo == LO_BASE)),
      .wr_blk   (sel & (lo == LO_BLK)),
      .wr_ctrl  (sel & (lo == LO_CTRL)),
      .wdata    (req_wdata),
      .done_evt (done_evt[n]),
      .berr_evt (berr_evt[n]),
      .regs_q   (ch_q[n])
    );
    assign busy[n] = ch_q[n].ctrl[BUSY_BIT];
  end

  dma_arb_reg #(.NUM_CH(NUM_CH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr & arb_hit),
    .wdata   (req_wdata),
    .busy    (busy),
    .arb_q   (arb_q),
    .may_run (may_run)
  );

  dma_irq_reg #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr & int_hit),
    .wdata    (req_wdata),
    .done_evt (done_evt),
    .berr_evt (berr_evt),
    .int_q    (int_q),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (arb_hit) begin
      rd_mux = arb_q;
    end else if (int_hit) begin
      rd_mux = int_q;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (chan_hit && int'(idx) == n) begin
          case (lo)
            LO_BASE: rd_mux = ch_q[n].base;
            LO_BLK:  rd_mux = ch_q[n].blk;
            LO_CTRL: rd_mux = ch_q[n].ctrl;
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  // R12
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
endmodule

// File: tb/tb_dma_regirq_ctrl.sv
module tb_dma_regirq_ctrl;
  localparam int NCH = 7;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h70, 32'h0,          32'h0765_4321},  // R1 arbitration reset
    '{1'b0, 8'h74, 32'h0,          32'h0},          // R1 interrupt reset
    '{1'b0, 8'h68, 32'h0,          32'h0},          // R1 channel reset
    '{1'b1, 8'h00, 32'hDEAD_BEEF,  32'hDEAD_BEEF},  // R2 ch0 base
    '{1'b1, 8'h64, 32'h1234_5678,  32'h1234_5678},  // R2 ch6 block
    '{1'b1, 8'h1C, 32'hFFFF_FFFF,  32'h0},          // R3 hole in window
    '{1'b1, 8'h7C, 32'hFFFF_FFFF,  32'h0},          // R3 channel-7 window
    '{1'b1, 8'h74, 32'hFFFF_FFFF,  32'h80FF_803F},  // R4 masked write
    '{1'b1, 8'h74, 32'h0,          32'h0},          // R4 clear settings
    '{1'b1, 8'h28, 32'h0100_0000,  32'h0100_0000}   // R2 ch2 control
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] done_evt = '0, berr_evt = '0;
  logic [NCH-1:0] may_run;
  logic irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  dma_regirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .done_evt(done_evt), .berr_evt(berr_evt),
    .may_run(may_run), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] be);
    @(negedge clk);
    done_evt = dn; berr_evt = be;
    @(negedge clk);
    done_evt = '0; berr_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 may_run", {25'b0, may_run}, 32'd0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        cpu_write(VECS[i].addr, VECS[i].wdata);
        check("R12 no response to write", {31'b0, rsp_valid}, 32'd0);
      end
      cpu_read(VECS[i].addr, rv);
      check($sformatf("vector %0d addr %h", i, VECS[i].addr), rv, VECS[i].exp);
      if (i == 7) check("R9 irq from bus-error bit", {31'b0, irq}, 32'd1);
    end
    // R3: the writes to the holes left the other words untouched
    cpu_read(8'h00, rv); check("R3 base kept", rv, 32'hDEAD_BEEF);
    check("R9 irq low", {31'b0, irq}, 32'd0);

    // R8: ch2 busy but master enable (bit 11) is 0 at reset pattern
    check("R8 gated off", {25'b0, may_run}, 32'd0);
    cpu_write(8'h70, 32'h0765_4B21);
    check("R8 enabled", {25'b0, may_run}, 32'h04);

    // R6: completion with interrupt enable off
    pulse(7'h04, 7'h00);
    check("R8 busy cleared drops may_run", {25'b0, may_run}, 32'd0);
    cpu_read(8'h28, rv); check("R6 busy cleared", rv, 32'h0);
    cpu_read(8'h74, rv); check("R6 no flag when disabled", rv, 32'h0);

    // R6 with enable: bit23 + bit18
    cpu_write(8'h74, 32'h0084_0000);
    cpu_write(8'h28, 32'h0100_0000);
    pulse(7'h04, 7'h00);
    cpu_read(8'h74, rv); check("R6 flag set / R9 master", rv, 32'h8484_0000);
    check("R9 irq high", {31'b0, irq}, 32'd1);

    // R5: zero leaves, one clears
    cpu_write(8'h74, 32'h0084_0000);
    cpu_read(8'h74, rv); check("R5 zero keeps flag", rv, 32'h8484_0000);
    cpu_write(8'h74, 32'h0484_0000);
    cpu_read(8'h74, rv); check("R5 one clears flag", rv, 32'h0084_0000);
    check("R9 irq dropped", {31'b0, irq}, 32'd0);

    // R7: bus error on ch5 with its enable (bit21) clear
    cpu_write(8'h58, 32'h0100_0000);
    pulse(7'h00, 7'h20);
    cpu_read(8'h58, rv); check("R7 busy cleared", rv, 32'h0);
    cpu_read(8'h74, rv); check("R7 error bit and flag", rv, 32'hA084_8000);
    check("R9 irq on error", {31'b0, irq}, 32'd1);
    cpu_write(8'h74, 32'h2084_0000);
    cpu_read(8'h74, rv); check("R4 error bit cleared by write", rv, 32'h0084_0000);

    // R10: set and clear of flag 26 in the same cycle
    cpu_write(8'h28, 32'h0100_0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h74; req_wdata = 32'h0484_0000;
    done_evt = 7'h04;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; done_evt = '0;
    cpu_read(8'h74, rv); check("R10 set wins", rv, 32'h8484_0000);

    // R9: master gate off hides the flag
    cpu_write(8'h74, 32'h0004_0000);
    cpu_read(8'h74, rv); check("R9 gate off", rv, 32'h0404_0000);
    check("R9 irq gated", {31'b0, irq}, 32'd0);

    // R11: write to control and completion in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h28; req_wdata = 32'h0100_00A5;
    done_evt = 7'h04;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; done_evt = '0;
    cpu_read(8'h28, rv); check("R11 write wins", rv, 32'h0100_00A5);
    check("R8 may_run after write", {25'b0, may_run}, 32'h04);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule